// File: doc/BRIEF.md
# Conflict Bypass Line Buffer

This block is a small, fully associative store of cache lines that sits beside a set-associative cache. Its job is to take a line that a privileged (protocol) thread needs when the cache set it maps to cannot accept the line without risking a resource deadlock. The probe runs alongside the main cache probe, and the result is registered on the same edge a cache hit would be. A hit therefore costs no extra cycle.

A fill is taken only when it comes from the privileged thread and the fill port also signals an index conflict in the main cache. Every other fill is left to the cache and does not disturb this buffer. Replacement is least-recently-used. The order is kept as a rank per entry, where rank 0 is the most recent and rank ENTRIES-1 is the oldest. When a dirty line is pushed out, its address and contents leave on an eviction output so they can be written back. The probe port can also store a new line into an entry it hits.

Top module: `bypass_buffer`

## Requirements
- R1: After reset every entry is invalid, and `lk_hit_o`, `lk_data_o`, `ev_valid_o`, `ev_addr_o` and `ev_data_o` are all zero.
- R2: A fill allocates only when `fill_valid_i`, `fill_prot_i` and `fill_conflict_i` are all 1. Any other fill changes no entry, no data and no LRU rank.
- R3: A probe with `lk_valid_i` high that matches a valid entry raises `lk_hit_o` on the next clock edge, with that entry's stored line on `lk_data_o`. A miss, or a cycle with no probe, gives `lk_hit_o` low and `lk_data_o` zero.
- R4: A new line goes to the lowest-numbered invalid entry. When every entry is valid, the new line replaces the least-recently-used entry.
- R5: A probe hit and an allocating fill each make their entry the most recent. When both touch different entries in one cycle, the probe's update is applied first and the fill's entry ends up most recent.
- R6: When an allocation replaces a valid dirty entry, `ev_valid_o` is 1 on the next edge, and `ev_addr_o`/`ev_data_o` hold the replaced address and line. Replacing a clean entry leaves `ev_valid_o` at 0.
- R7: A probe hit with `lk_we_i` high returns the line as it was before the write, stores `lk_wdata_i` into the entry and marks the entry dirty.
- R8: When a probe and an allocating fill name the same address in one cycle, the probe reports a miss, its write is dropped, and the fill is applied.
- R9: An allocating fill to an address already held overwrites that entry in place. It causes no eviction, and the entry's dirty flag becomes the old flag OR `fill_dirty_i`. No address is ever held twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Probe request |
| lk_addr_i | input | ADDR_W | Line address to probe |
| lk_we_i | input | 1 | Store `lk_wdata_i` into the entry on a hit |
| lk_wdata_i | input | LINE_W | Line to store on a write hit |
| lk_hit_o | output | 1 | Probe hit, one cycle after the request |
| lk_data_o | output | LINE_W | Line read on a hit, zero otherwise |
| fill_valid_i | input | 1 | Fill request |
| fill_prot_i | input | 1 | Fill comes from the privileged thread |
| fill_conflict_i | input | 1 | Main cache set cannot take the line |
| fill_addr_i | input | ADDR_W | Line address of the fill |
| fill_data_i | input | LINE_W | Line contents of the fill |
| fill_dirty_i | input | 1 | Fill line is modified |
| ev_valid_o | output | 1 | A dirty line was replaced |
| ev_addr_o | output | ADDR_W | Address of the replaced line |
| ev_data_o | output | LINE_W | Contents of the replaced line |

## Verification
Each result is registered exactly once, so the probe hit and data (R3, R7, R8) and the eviction record (R6) for inputs sampled on one rising edge are all due on that same edge. They are replaced on the next edge. The bench applies stimulus on the falling edge and advances a behavioural model (a recency queue and plain arrays) by one step. It then compares all five outputs 1 ns after the following rising edge, so every comparison falls in the one cycle where that result is valid. Effects on state (R2, R4, R5, R9) are checked through later probes and evictions that depend on them.

// File: rtl/bypass_buffer_pkg.sv
package bypass_buffer_pkg;

    // How an allocating fill lands in the buffer.
    typedef enum logic [1:0] {
        FK_NONE   = 2'd0,
        FK_UPDATE = 2'd1,
        FK_FREE   = 2'd2,
        FK_EVICT  = 2'd3
    } fill_kind_e;

endpackage

// File: rtl/bb_cam.sv
module bb_cam #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32
) (
    input  logic [ENTRIES-1:0]             valid_i,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tags_i,
    input  logic [ADDR_W-1:0]              key_i,
    output logic [ENTRIES-1:0]             match_o
);

    // One comparator per entry, all in parallel.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (tags_i[g] == key_i);
    end

endmodule

// File: rtl/bb_first_set.sv
module bb_first_set #(
    parameter  int WIDTH = 16,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Lowest set bit wins.
    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/bypass_buffer.sv
module bypass_buffer
    import bypass_buffer_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int LINE_W  = 256
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lk_valid_i,
    input  logic [ADDR_W-1:0] lk_addr_i,
    input  logic              lk_we_i,
    input  logic [LINE_W-1:0] lk_wdata_i,
    output logic              lk_hit_o,
    output logic [LINE_W-1:0] lk_data_o,
    input  logic              fill_valid_i,
    input  logic              fill_prot_i,
    input  logic              fill_conflict_i,
    input  logic [ADDR_W-1:0] fill_addr_i,
    input  logic [LINE_W-1:0] fill_data_i,
    input  logic              fill_dirty_i,
    output logic              ev_valid_o,
    output logic [ADDR_W-1:0] ev_addr_o,
    output logic [LINE_W-1:0] ev_data_o
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int AGE_W = IDX_W;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] data;
        logic [AGE_W-1:0]  age;   // 0 = most recent
    } ent_t;

    typedef ent_t [ENTRIES-1:0] ent_arr_t;

    typedef struct packed {
        ent_arr_t          ent;
        logic              lk_hit;
        logic [LINE_W-1:0] lk_data;
        logic              ev_valid;
        logic [ADDR_W-1:0] ev_addr;
        logic [LINE_W-1:0] ev_data;
    } state_t;

    state_t st_q, st_d;

    // Ranks start as a permutation 0..ENTRIES-1 so the order stays total.
    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < ENTRIES; i++) s.ent[i].age = AGE_W'(i);
        return s;
    endfunction

    // Move entry k to rank 0; entries that were more recent age by one.
    function automatic ent_arr_t touch(ent_arr_t e, logic [IDX_W-1:0] k);
        ent_arr_t         r;
        logic [AGE_W-1:0] a;
        r = e;
        a = e[k].age;
        for (int i = 0; i < ENTRIES; i++) begin
            if (IDX_W'(i) == k)    r[i].age = '0;
            else if (e[i].age < a) r[i].age = e[i].age + AGE_W'(1);
        end
        return r;
    endfunction

    // ---------------------------------------------------------------
    // Parallel tag compare and index selection
    // ---------------------------------------------------------------
    logic [ENTRIES-1:0]             valid_vec, free_vec, oldest_vec;
    logic [ENTRIES-1:0]             lk_match, fill_match;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_arr;
    logic                           lk_any, fill_any, free_any;
    logic [IDX_W-1:0]               lk_idx, fill_idx, free_idx;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            valid_vec[i]  = st_q.ent[i].valid;
            tag_arr[i]    = st_q.ent[i].addr;
            oldest_vec[i] = (st_q.ent[i].age == AGE_W'(ENTRIES - 1));
        end
    end

    assign free_vec = ~valid_vec;

    bb_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lk_cam (
        .valid_i (valid_vec),
        .tags_i  (tag_arr),
        .key_i   (lk_addr_i),
        .match_o (lk_match)
    );

    bb_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_fill_cam (
        .valid_i (valid_vec),
        .tags_i  (tag_arr),
        .key_i   (fill_addr_i),
        .match_o (fill_match)
    );

    bb_first_set #(.WIDTH(ENTRIES)) u_lk_sel (
        .vec_i (lk_match),
        .any_o (lk_any),
        .idx_o (lk_idx)
    );

    bb_first_set #(.WIDTH(ENTRIES)) u_fill_sel (
        .vec_i (fill_match),
        .any_o (fill_any),
        .idx_o (fill_idx)
    );

    bb_first_set #(.WIDTH(ENTRIES)) u_free_sel (
        .vec_i (free_vec),
        .any_o (free_any),
        .idx_o (free_idx)
    );

    // ---------------------------------------------------------------
    // Next-state computation
    // ---------------------------------------------------------------
    logic             fill_alloc, same_addr, lk_take;
    logic [IDX_W-1:0] old_idx, tgt_idx;
    fill_kind_e       kind;

    always_comb begin
        st_d          = st_q;
        st_d.lk_hit   = 1'b0;
        st_d.lk_data  = '0;
        st_d.ev_valid = 1'b0;
        st_d.ev_addr  = '0;
        st_d.ev_data  = '0;

        fill_alloc = fill_valid_i && fill_prot_i && fill_conflict_i;
        same_addr  = fill_alloc && lk_valid_i && (lk_addr_i == fill_addr_i);
        lk_take    = lk_valid_i && lk_any && !same_addr;

        // Probe side: read, optional write, recency update.
        if (lk_take) begin
            st_d.lk_hit  = 1'b1;
            st_d.lk_data = st_q.ent[lk_idx].data;
            if (lk_we_i) begin
                st_d.ent[lk_idx].data  = lk_wdata_i;
                st_d.ent[lk_idx].dirty = 1'b1;
            end
            st_d.ent = touch(st_d.ent, lk_idx);
        end

        // Oldest entry after the probe's recency update.
        old_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (st_d.ent[i].age == AGE_W'(ENTRIES - 1)) old_idx = IDX_W'(i);
        end

        kind    = FK_NONE;
        tgt_idx = '0;
        if (fill_alloc) begin
            if (fill_any) begin
                kind    = FK_UPDATE;
                tgt_idx = fill_idx;
            end else if (free_any) begin
                kind    = FK_FREE;
                tgt_idx = free_idx;
            end else begin
                kind    = FK_EVICT;
                tgt_idx = old_idx;
            end
        end

        if (kind == FK_EVICT && st_d.ent[tgt_idx].dirty) begin
            st_d.ev_valid = 1'b1;
            st_d.ev_addr  = st_d.ent[tgt_idx].addr;
            st_d.ev_data  = st_d.ent[tgt_idx].data;
        end

        if (kind != FK_NONE) begin
            st_d.ent[tgt_idx].dirty = ((kind == FK_UPDATE) ? st_d.ent[tgt_idx].dirty : 1'b0)
                                      | fill_dirty_i;
            st_d.ent[tgt_idx].valid = 1'b1;
            st_d.ent[tgt_idx].addr  = fill_addr_i;
            st_d.ent[tgt_idx].data  = fill_data_i;
            st_d.ent = touch(st_d.ent, tgt_idx);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= reset_state();
        else         st_q <= st_d;
    end

    assign lk_hit_o   = st_q.lk_hit;
    assign lk_data_o  = st_q.lk_data;
    assign ev_valid_o = st_q.ev_valid;
    assign ev_addr_o  = st_q.ev_addr;
    assign ev_data_o  = st_q.ev_data;

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    // R3
    hit_needs_probe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_hit_o |-> $past(lk_valid_i));

    // R3
    miss_data_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lk_hit_o |-> (lk_data_o == '0));

    // R6
    evict_needs_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_valid_o |-> $past(fill_valid_i && fill_prot_i && fill_conflict_i));

    // R8
    same_addr_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_valid_i && fill_valid_i && fill_prot_i && fill_conflict_i
         && (lk_addr_i == fill_addr_i)) |=> !lk_hit_o);

    // R9
    single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(lk_match) && $onehot0(fill_match));

    // R4
    one_oldest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(oldest_vec) == 1);

endmodule

// File: tb/bypass_buffer_bench.sv
module bypass_buffer_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N  = 4;
    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0, lk_we = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic [DW-1:0] lk_wdata = '0;
    logic          fill_valid = 1'b0, fill_prot = 1'b0, fill_conflict = 1'b0, fill_dirty = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] fill_data = '0;
    logic          lk_hit, ev_valid;
    logic [DW-1:0] lk_data, ev_data;
    logic [AW-1:0] ev_addr;

    always #4 clk = ~clk;   // 125 MHz

    bypass_buffer #(.ENTRIES(N), .ADDR_W(AW), .LINE_W(DW)) u_bypass_buffer (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .lk_valid_i      (lk_valid),
        .lk_addr_i       (lk_addr),
        .lk_we_i         (lk_we),
        .lk_wdata_i      (lk_wdata),
        .lk_hit_o        (lk_hit),
        .lk_data_o       (lk_data),
        .fill_valid_i    (fill_valid),
        .fill_prot_i     (fill_prot),
        .fill_conflict_i (fill_conflict),
        .fill_addr_i     (fill_addr),
        .fill_data_i     (fill_data),
        .fill_dirty_i    (fill_dirty),
        .ev_valid_o      (ev_valid),
        .ev_addr_o       (ev_addr),
        .ev_data_o       (ev_data)
    );

    int    vecs = 0;
    int    bad  = 0;
    bit    done = 0;
    string req  = "R1";

    // Reference model: plain arrays plus a recency queue (front = most recent).
    bit            mv [N];
    bit            mdy[N];
    logic [AW-1:0] ma [N];
    logic [DW-1:0] md [N];
    int            order[$];

    bit            e_hit, e_ev;
    logic [DW-1:0] e_data, e_evd;
    logic [AW-1:0] e_eva;

    task automatic model_reset();
        order.delete();
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mdy[i] = 0; ma[i] = '0; md[i] = '0;
            order.push_back(i);
        end
        e_hit = 0; e_ev = 0; e_data = '0; e_evd = '0; e_eva = '0;
    endtask

    task automatic promote(int k);
        for (int i = 0; i < order.size(); i++) begin
            if (order[i] == k) begin
                order.delete(i);
                break;
            end
        end
        order.push_front(k);
    endtask

    task automatic model_step();
        bit alloc, same;
        int li, fi, tgt;
        alloc = fill_valid && fill_prot && fill_conflict;
        same  = alloc && lk_valid && (lk_addr == fill_addr);
        li = -1; fi = -1; tgt = -1;
        e_hit = 0; e_data = '0; e_ev = 0; e_eva = '0; e_evd = '0;
        for (int i = 0; i < N; i++) if (mv[i] && ma[i] == lk_addr) li = i;
        if (lk_valid && li >= 0 && !same) begin
            e_hit  = 1;
            e_data = md[li];
            if (lk_we) begin md[li] = lk_wdata; mdy[li] = 1; end
            promote(li);
        end
        if (alloc) begin
            for (int i = 0; i < N; i++) if (mv[i] && ma[i] == fill_addr) fi = i;
            if (fi >= 0) begin
                tgt = fi;
                mdy[tgt] = mdy[tgt] | fill_dirty;
            end else begin
                for (int i = N - 1; i >= 0; i--) if (!mv[i]) tgt = i;
                if (tgt < 0) begin
                    tgt = order[order.size() - 1];
                    if (mdy[tgt]) begin e_ev = 1; e_eva = ma[tgt]; e_evd = md[tgt]; end
                end
                mdy[tgt] = fill_dirty;
            end
            mv[tgt] = 1; ma[tgt] = fill_addr; md[tgt] = fill_data;
            promote(tgt);
        end
    endtask

    task automatic check_one(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        check_one("lk_hit",   DW'(lk_hit),   DW'(e_hit));
        check_one("lk_data",  lk_data,       e_data);
        check_one("ev_valid", DW'(ev_valid), DW'(e_ev));
        check_one("ev_addr",  DW'(ev_addr),  DW'(e_eva));
        check_one("ev_data",  ev_data,       e_evd);
    endtask

    // One clock: drive on the falling edge, compare after the rising edge.
    task automatic drive(bit lv, int la, bit lwe, int lwd,
                         bit fv, bit fp, bit fc, int fa, int fd, bit fdt);
        @(negedge clk);
        lk_valid = lv; lk_addr = AW'(la); lk_we = lwe; lk_wdata = DW'(lwd);
        fill_valid = fv; fill_prot = fp; fill_conflict = fc;
        fill_addr = AW'(fa); fill_data = DW'(fd); fill_dirty = fdt;
        model_step();
        @(posedge clk);
        #1;
        check_all();
    endtask

    task automatic probe(int a);                 drive(1, a, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic put(int a, int d, bit dirty); drive(0, 0, 0, 0, 1, 1, 1, a, d, dirty); endtask
    task automatic idle();                       drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R1: reset state
        req = "R1";
        repeat (3) @(posedge clk);
        #1;
        check_all();
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        probe(1);

        // R2: fills lacking any one qualifier are ignored
        req = "R2";
        drive(0, 0, 0, 0, 1, 0, 1, 1, 'h11, 1);
        drive(0, 0, 0, 0, 1, 1, 0, 1, 'h12, 1);
        drive(0, 0, 0, 0, 0, 1, 1, 1, 'h13, 1);
        probe(1);

        // R3: fill four lines, probe each
        req = "R3";
        for (int a = 1; a <= 4; a++) put(a, 'h1000 + a, 0);
        for (int a = 1; a <= 4; a++) probe(a);
        probe(9);

        // R5: hit on 1 makes 2 the oldest; R4: fill 5 replaces 2
        req = "R5";
        probe(1);
        req = "R4";
        put(5, 'h1005, 0);
        probe(2);
        probe(5);

        // R6: dirty lines leave through the eviction port, clean ones do not
        req = "R6";
        put(6, 'h2006, 1);
        put(7, 'h2007, 1);
        for (int a = 8; a <= 12; a++) put(a, 'h2000 + a, a[0]);

        // R7: write hit returns old data, later eviction carries new data
        req = "R7";
        drive(1, 12, 1, 'h7777, 0, 0, 0, 0, 0, 0);
        probe(12);
        for (int a = 13; a <= 16; a++) put(a, 'h3000 + a, 0);

        // R8: same address probe and fill in one cycle
        req = "R8";
        drive(1, 16, 1, 'h5555, 1, 1, 1, 16, 'h8888, 0);
        probe(16);

        // R5: probe hit and fill to other entries in one cycle
        req = "R5";
        drive(1, 13, 0, 0, 1, 1, 1, 20, 'h4020, 1);
        put(21, 'h4021, 0);
        probe(13);

        // R9: refill a resident line in place, dirty flag kept
        req = "R9";
        put(20, 'h9020, 0);
        probe(20);
        for (int a = 30; a <= 33; a++) put(a, 'h6000 + a, 0);

        // Mixed traffic over a small address space
        req = "R4";
        for (int n = 0; n < 3000; n++) begin
            drive($urandom_range(0, 1), $urandom_range(0, 9), ($urandom_range(0, 3) == 0),
                  $urandom_range(0, 65535),
                  $urandom_range(0, 1), ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0),
                  $urandom_range(0, 9), $urandom_range(0, 65535), $urandom_range(0, 1));
        end
        idle();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule